// File: doc/BRIEF.md
# GPIO Bank Register Controller

This block gives software control over one bank of up to 64 general-purpose pins through a synchronous register port with 64-bit data. Software changes output levels by writing masks to a set register and a clear register; a read-modify-write of the levels is never needed. Each pin has its own configuration word. The word holds an output enable, a polarity invert, an open-drain select, an 8-bit glitch-filter field that is stored for a neighbouring block, and a 10-bit function select. When the function select is non-zero, another on-chip function owns the pin. The controller then stops driving that pin and discards set and clear bits aimed at it.

Pin levels are read through a two-flop synchroniser, and the polarity invert is applied after it. The invert acts on both directions, so an inverted pin reads and writes in the same logical sense. In open-drain mode a pin is either pulled low or released. The pulled state is the inverse of the latch level, which lets the invert bit restore the natural sense. A read-only constants register reports the pin count and the base interrupt vector. Both are parameters.

The register port has one address. Reads are registered: data appears one cycle after the read strobe and holds until the next read. A read and a write may target the same address in the same cycle.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every output latch and every configuration word is zero, so `pin_oe` and `pin_out` are all zero and configuration reads return zero.
- R2: A write to offset 0x8 sets the output latch of every GPIO-owned pin whose data bit is 1 and leaves the others unchanged. Reads of offset 0x8 or 0x10 return the latch, zero-extended.
- R3: A write to offset 0x10 clears the latch of every GPIO-owned pin whose data bit is 1 and leaves the others unchanged.
- R4: Offset 0x90 reads the pin count in bits 7:0 and the vector base in bits 15:8, with zeros above. Writes to it have no effect.
- R5: The configuration word of pin p sits at 0x400 + 8*p. Bit 0 is output enable, bit 1 is invert, bits 11:4 are the filter field, bit 12 is open-drain and bits 25:16 are the function select. It reads back exactly these fields, and all other bits read zero.
- R6: For an unowned pin in push-pull mode (bit 12 clear), `pin_out` equals latch XOR invert and `pin_oe` equals the enable bit.
- R7: For an unowned pin in open-drain mode, `pin_out` is 0 and `pin_oe` equals enable AND (latch XOR invert). The pin never drives high.
- R8: A pin with a non-zero function select has `pin_oe` and `pin_out` at 0, and its latch ignores set and clear writes.
- R9: Offset 0x0 reads the synchronised pin level XOR invert for each pin. The value is valid for a read issued two or more cycles after the pin changes. Bits at or above the pin count read 0.
- R10: `reg_rdata` updates on the clock edge that samples `reg_rd` and holds its value while `reg_rd` is low. A read in the same cycle as a write to the same address returns the value before the write.
- R11: Misaligned addresses, unmapped addresses and configuration addresses for pins at or above the pin count read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 12 | Byte address, 8-byte aligned |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Pad output levels |
| pin_oe | output | NUM_PINS | Pad output enables |

## Verification
Two situations put two functions in the same cycle. The first is a read and a write aimed at the same register in one cycle. The bench provokes it for the set register and for a configuration word, and expects the read to return the pre-write value while a second read returns the updated one. The second is a set or clear mask that reaches pins another function owns. Random configuration words give about one pin in four a non-zero function select, and the bench model, which discards masked bits for owned pins, is compared with the latch readback and with the pad outputs after every operation.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int DATA_W    = 64;
    localparam int ADDR_W    = 12;
    localparam int CFG_IDX_W = 7;

    localparam logic [ADDR_W-1:0] OFS_RX    = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_SET   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_CONST = 12'h090;

    typedef struct packed {
        logic [9:0] fsel;
        logic       od;
        logic [7:0] filt;
        logic       inv;
        logic       oe;
    } pin_cfg_t;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_RX,
        REG_SET,
        REG_CLR,
        REG_CONST,
        REG_CFG
    } reg_sel_e;

    function automatic logic [DATA_W-1:0] cfg_to_word(input pin_cfg_t c);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[0]     = c.oe;
        w[1]     = c.inv;
        w[11:4]  = c.filt;
        w[12]    = c.od;
        w[25:16] = c.fsel;
        return w;
    endfunction

    function automatic pin_cfg_t word_to_cfg(input logic [DATA_W-1:0] w);
        pin_cfg_t c;
        c.oe   = w[0];
        c.inv  = w[1];
        c.filt = w[11:4];
        c.od   = w[12];
        c.fsel = w[25:16];
        return c;
    endfunction

endpackage

// File: rtl/gpio_cfg_file.sv
module gpio_cfg_file
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 50
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CFG_IDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]    wr_word,
    input  logic [CFG_IDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0]    rd_word,
    output logic [NUM_PINS-1:0]  oe_v,
    output logic [NUM_PINS-1:0]  inv_v,
    output logic [NUM_PINS-1:0]  od_v,
    output logic [NUM_PINS-1:0]  own_v
);

    pin_cfg_t cfg_q [NUM_PINS];

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[i] <= '0;
            else if (wr_en && wr_idx == CFG_IDX_W'(i))
                cfg_q[i] <= word_to_cfg(wr_word);
        end
        assign oe_v[i]  = cfg_q[i].oe;
        assign inv_v[i] = cfg_q[i].inv;
        assign od_v[i]  = cfg_q[i].od;
        assign own_v[i] = |cfg_q[i].fsel;
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_PINS; i++)
            if (rd_idx == CFG_IDX_W'(i))
                rd_word = cfg_to_word(cfg_q[i]);
    end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 50
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic                clr_en,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_PINS-1:0] own_v,
    output logic [NUM_PINS-1:0] lat
);

    logic [NUM_PINS-1:0] hit, set_m, clr_m, lat_nxt;

    always_comb begin
        hit     = wdata[NUM_PINS-1:0] & ~own_v;
        set_m   = set_en ? hit : '0;
        clr_m   = clr_en ? hit : '0;
        lat_nxt = (lat & ~clr_m) | set_m;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat <= '0;
        else        lat <= lat_nxt;
    end

    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((lat & $past(wdata[NUM_PINS-1:0] & ~own_v)) == $past(wdata[NUM_PINS-1:0] & ~own_v)));

    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((lat & $past(wdata[NUM_PINS-1:0] & ~own_v)) == '0));

    assert_owned_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((lat ^ $past(lat)) & $past(own_v)) == '0));

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
    parameter int NUM_PINS = 50
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] lat,
    input  logic [NUM_PINS-1:0] oe_v,
    input  logic [NUM_PINS-1:0] inv_v,
    input  logic [NUM_PINS-1:0] od_v,
    input  logic [NUM_PINS-1:0] own_v,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_drv
        logic lvl;
        always_comb begin
            lvl = lat[i] ^ inv_v[i];
            if (own_v[i]) begin
                pin_out[i] = 1'b0;
                pin_oe[i]  = 1'b0;
            end else if (od_v[i]) begin
                pin_out[i] = 1'b0;
                pin_oe[i]  = oe_v[i] & lvl;
            end else begin
                pin_out[i] = lvl;
                pin_oe[i]  = oe_v[i];
            end
        end

        assert_od_never_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
            od_v[i] |-> !(pin_oe[i] && pin_out[i]));

        assert_owned_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
            own_v[i] |-> !pin_oe[i]);
    end

endmodule

// File: rtl/gpio_rx_sync.sv
module gpio_rx_sync #(
    parameter int NUM_PINS = 50
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] inv_v,
    output logic [NUM_PINS-1:0] rx
);

    logic [NUM_PINS-1:0] s1, s2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= pin_in;
            s2 <= s1;
        end
    end

    assign rx = s2 ^ inv_v;

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 50,
    parameter int VEC_BASE = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    localparam logic [DATA_W-1:0] CONST_WORD =
        {48'd0, 8'(VEC_BASE), 8'(NUM_PINS)};

    reg_sel_e             sel;
    logic [CFG_IDX_W-1:0] cfg_idx;
    logic [DATA_W-1:0]    cfg_word, rd_nxt;
    logic [NUM_PINS-1:0]  lat, rx, oe_v, inv_v, od_v, own_v;

    assign cfg_idx = reg_addr[3 +: CFG_IDX_W];

    always_comb begin
        sel = REG_NONE;
        if (reg_addr == OFS_RX)         sel = REG_RX;
        else if (reg_addr == OFS_SET)   sel = REG_SET;
        else if (reg_addr == OFS_CLR)   sel = REG_CLR;
        else if (reg_addr == OFS_CONST) sel = REG_CONST;
        else if (reg_addr[11:10] == 2'b01 && reg_addr[2:0] == 3'b000 &&
                 32'(cfg_idx) < NUM_PINS)
            sel = REG_CFG;
    end

    always_comb begin
        unique case (sel)
            REG_RX:            rd_nxt = DATA_W'(rx);
            REG_SET, REG_CLR:  rd_nxt = DATA_W'(lat);
            REG_CONST:         rd_nxt = CONST_WORD;
            REG_CFG:           rd_nxt = cfg_word;
            default:           rd_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_nxt;
    end

    gpio_cfg_file #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr && sel == REG_CFG), .wr_idx(cfg_idx), .wr_word(reg_wdata),
        .rd_idx(cfg_idx), .rd_word(cfg_word),
        .oe_v(oe_v), .inv_v(inv_v), .od_v(od_v), .own_v(own_v)
    );

    gpio_out_latch #(.NUM_PINS(NUM_PINS)) u_lat (
        .clk(clk), .rst_n(rst_n),
        .set_en(reg_wr && sel == REG_SET), .clr_en(reg_wr && sel == REG_CLR),
        .wdata(reg_wdata), .own_v(own_v), .lat(lat)
    );

    gpio_pin_drive #(.NUM_PINS(NUM_PINS)) u_drv (
        .clk(clk), .rst_n(rst_n), .lat(lat), .oe_v(oe_v), .inv_v(inv_v),
        .od_v(od_v), .own_v(own_v), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    gpio_rx_sync #(.NUM_PINS(NUM_PINS)) u_rx (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .inv_v(inv_v), .rx(rx)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == '0 && pin_oe == '0));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

endmodule

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;

    localparam int NP = 50;
    localparam int VB = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [63:0]   reg_wdata = '0;
    logic [63:0]   reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;

    int checks = 0;
    int fails  = 0;

    logic [NP-1:0] m_lat = '0;
    logic [63:0]   m_cfg [NP];

    always #10 clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(NP), .VEC_BASE(VB)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] cfg_mask(input logic [63:0] w);
        return w & 64'h0000_0000_03FF_1FF3;
    endfunction

    function automatic logic [NP-1:0] own_vec();
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++) v[i] = |m_cfg[i][25:16];
        return v;
    endfunction

    function automatic logic [NP-1:0] inv_vec();
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++) v[i] = m_cfg[i][1];
        return v;
    endfunction

    task automatic bus(input logic wr, input logic rd, input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic write_model(input logic [11:0] a, input logic [63:0] d);
        logic [NP-1:0] hit;
        hit = d[NP-1:0] & ~own_vec();
        if (a == 12'h008) m_lat = m_lat | hit;
        else if (a == 12'h010) m_lat = m_lat & ~hit;
        else if (a[11:10] == 2'b01 && a[2:0] == 3'b000 && int'(a[9:3]) < NP)
            m_cfg[a[9:3]] = cfg_mask(d);
        bus(1'b1, 1'b0, a, d);
    endtask

    task automatic check_pins();
        logic [NP-1:0] eo, eoe;
        for (int i = 0; i < NP; i++) begin
            logic lvl;
            lvl = m_lat[i] ^ m_cfg[i][1];
            if (|m_cfg[i][25:16]) begin eo[i] = 1'b0; eoe[i] = 1'b0; end
            else if (m_cfg[i][12]) begin eo[i] = 1'b0; eoe[i] = m_cfg[i][0] & lvl; end
            else begin eo[i] = lvl; eoe[i] = m_cfg[i][0]; end
        end
        chk("R6/R7/R8 pin_out", 64'(pin_out), 64'(eo));
        chk("R6/R7/R8 pin_oe", 64'(pin_oe), 64'(eoe));
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] w;
        int p;
        for (int i = 0; i < NP; i++) m_cfg[i] = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 pin_oe", 64'(pin_oe), 64'd0);
        chk("R1 pin_out", 64'(pin_out), 64'd0);
        bus(1'b0, 1'b1, 12'h400, '0);
        chk("R1 cfg0", reg_rdata, 64'd0);
        bus(1'b0, 1'b1, 12'h008, '0);
        chk("R1 latch", reg_rdata, 64'd0);

        // R4 constants, write ignored
        bus(1'b1, 1'b1, 12'h090, '1);
        chk("R4 const", reg_rdata, 64'h0000_0000_0000_3032);
        bus(1'b0, 1'b1, 12'h090, '0);
        chk("R4 const after write", reg_rdata, 64'h0000_0000_0000_3032);

        // R2 / R3 directed
        write_model(12'h008, 64'hFFFF_0000_0000_00A5);
        bus(1'b0, 1'b1, 12'h010, '0);
        chk("R2 set readback", reg_rdata, 64'(m_lat));
        write_model(12'h010, 64'h0000_0000_0000_0021);
        bus(1'b0, 1'b1, 12'h008, '0);
        chk("R3 clr readback", reg_rdata, 64'(m_lat));

        // R5 all bits written, only fields read back
        write_model(12'h400 + 12'd8 * 12'd3, '1);
        bus(1'b0, 1'b1, 12'h400 + 12'd8 * 12'd3, '0);
        chk("R5 cfg fields", reg_rdata, 64'h0000_0000_03FF_1FF3);
        write_model(12'h400 + 12'd8 * 12'd3, 64'h0);

        // R6 push-pull, R7 open-drain with invert
        write_model(12'h400 + 12'd8 * 12'd1, 64'h1);
        write_model(12'h400 + 12'd8 * 12'd2, 64'h1003);
        check_pins();
        write_model(12'h008, 64'h6);
        check_pins();

        // R8 owned pin ignores set and clear
        write_model(12'h400 + 12'd8 * 12'd4, 64'h0001_0001);
        write_model(12'h008, 64'h10);
        bus(1'b0, 1'b1, 12'h008, '0);
        chk("R8 owned ignores set", reg_rdata, 64'(m_lat));
        check_pins();

        // R10 same-cycle read and write: old value returned, then new
        w = 64'(m_lat);
        bus(1'b1, 1'b1, 12'h008, 64'h300);
        m_lat = m_lat | (10'h300 & ~own_vec()[9:0]);
        chk("R10 read-during-write", reg_rdata, w);
        bus(1'b0, 1'b1, 12'h008, '0);
        chk("R10 read after write", reg_rdata, 64'(m_lat));
        repeat (3) @(negedge clk);
        chk("R10 hold", reg_rdata, 64'(m_lat));
        w = m_cfg[1];
        bus(1'b1, 1'b1, 12'h408, 64'h2);
        m_cfg[1] = 64'h2;
        chk("R10 cfg read-during-write", reg_rdata, w);

        // R11 unmapped / out of range
        bus(1'b1, 1'b1, 12'h400 + 12'd8 * 12'(NP), '1);
        chk("R11 cfg beyond count", reg_rdata, 64'd0);
        bus(1'b1, 1'b1, 12'h00C, '1);
        chk("R11 misaligned", reg_rdata, 64'd0);
        bus(1'b1, 1'b1, 12'h800, '1);
        chk("R11 unmapped", reg_rdata, 64'd0);
        bus(1'b0, 1'b1, 12'h008, '0);
        chk("R11 latch unchanged", reg_rdata, 64'(m_lat));
        check_pins();

        // R9 input sampling with invert
        pin_in = {NP{1'b1}} ^ NP'(64'h5);
        repeat (2) @(negedge clk);
        bus(1'b0, 1'b1, 12'h000, '0);
        chk("R9 rx", reg_rdata, 64'(pin_in ^ inv_vec()));

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 4);
            w = {$urandom, $urandom};
            if (op == 0) write_model(12'h008, w);
            else if (op == 1) write_model(12'h010, w);
            else if (op == 2) begin
                p = int'($urandom % NP);
                if ($urandom % 4 != 0) w[25:16] = '0;
                write_model(12'h400 + 12'(8 * p), w);
                bus(1'b0, 1'b1, 12'h400 + 12'(8 * p), '0);
                chk("R5 cfg random", reg_rdata, m_cfg[p]);
            end else begin
                pin_in = NP'(w);
                repeat (2) @(negedge clk);
                bus(1'b0, 1'b1, 12'h000, '0);
                chk("R9 rx random", reg_rdata, 64'(pin_in ^ inv_vec()));
            end
            bus(1'b0, 1'b1, 12'h010, '0);
            chk("R2/R3 latch random", reg_rdata, 64'(m_lat));
            check_pins();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule